// File: doc/BRIEF.md
# E1 CAS Signaling Insertion Multiplexer

This block sits on the transmit side of an E1 framer. Its job is to rebuild time slot 16 of every frame in a 16-frame channel-associated signaling (CAS) multiframe. The outgoing PCM stream enters one bit per 2.048 MHz bit clock. The framer's counters supply the current frame, time slot and bit position. For each bit of time slot 16 the block selects one of three sources: the PCM stream itself, a serial signaling stream aligned to it, or a bank of sixteen internal signaling bytes with one byte per frame. The output leaves one bit clock later, and every other time slot passes through unchanged.

Each half of time slot 16 has its own bit in a 32-bit source mask, so the block can mix stream signaling and bank signaling channel by channel. In frame n (1 to 15), the upper nibble of time slot 16 carries the ABCD bits of voice channel n and the lower nibble carries voice channel n+15. In frame 0, time slot 16 holds the multiframe alignment word together with the spare and remote-alarm bits. These come from bank byte 0 when both frame-0 mask bits are set.

Top module: `e1cas_ins_mux`

## Requirements
- R1: While `rst_n` is low, `pcm_out` is 0.
- R2: In every time slot other than 16, `pcm_out` equals `pcm_in` from one clock earlier, whatever the settings.
- R3: With `hw_sig_en` = 0 and `mask_en` = 0, the output stream equals the input stream bit for bit, delayed by one clock, across all 32 time slots and all 16 frames.
- R4: A time-slot-16 bit that is not taken from the bank comes from `sig_in` when `hw_sig_en` = 1, and from `pcm_in` when `hw_sig_en` = 0, with one clock of latency.
- R5: With `mask_en` = 1, consider a time-slot-16 bit in frame f and nibble half h (h = 0 for `bit_num` 0..3, h = 1 for `bit_num` 4..7). It is taken from the bank when `src_mask[f + 16*h]` is 1. For frames 1 to 15 this mask index is the time-slot number of the carried voice channel: channel f is at slot f, and channel f+15 is at slot f+16.
- R6: With `mask_en` = 0, `src_mask` has no effect on the output.
- R7: In frame 0, setting `src_mask` bits 0 and 16 makes time slot 16 equal bank byte 0 (for example 0Bh gives 0000 1011 on the line).
- R8: The two nibble halves of a frame choose their source independently. A half whose mask bit is 0 follows the stream even when the other half comes from the bank.
- R9: Bit 0 of each slot is the first bit on the line. Bank byte k occupies `sig_bank[8k+7:8k]`, and the bit sent at `bit_num` b of frame k is `sig_bank[8k+7-b]`, so the byte goes out MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_in | input | 1 | Outgoing serial PCM bit |
| sig_in | input | 1 | Serial signaling bit aligned to `pcm_in` |
| frame_num | input | 4 | Frame index within the multiframe, 0..15 |
| slot_num | input | 5 | Time slot index, 0..31 |
| bit_num | input | 3 | Bit index within the slot, 0 = first on line |
| hw_sig_en | input | 1 | Take stream signaling from `sig_in` instead of `pcm_in` |
| mask_en | input | 1 | Enable per-half bank selection through `src_mask` |
| src_mask | input | 32 | Per-slot source mask, 1 = internal bank |
| sig_bank | input | 128 | Sixteen internal signaling bytes, byte k at bits 8k+7..8k |
| pcm_out | output | 1 | Rebuilt PCM bit, one clock after its input |

## Verification
The assertions assume that `frame_num`, `slot_num` and `bit_num` name the bit currently present on `pcm_in` and `sig_in`. They also assume that the mask, the bank and both enables, as sampled on the same edge as the data bit, apply to that bit. The stimulus meets both conditions. It walks the position counters in true line order, bit by bit, through complete multiframes, and it changes data and configuration only on the falling edge, together with the position it belongs to. Random PCM and signaling bits are combined with random, all-zero and directed masks and bank contents, including the frame-0 alignment byte and frames with mixed halves.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;

  // Line structure of the E1 multiframe
  localparam int unsigned FRM_W      = 4;
  localparam int unsigned SLOT_W     = 5;
  localparam int unsigned BIT_W      = 3;
  localparam int unsigned NFRM       = 1 << FRM_W;
  localparam int unsigned NSLOT      = 1 << SLOT_W;
  localparam int unsigned SLOT_BITS  = 1 << BIT_W;
  localparam int unsigned BANK_W     = NFRM * SLOT_BITS;
  localparam int unsigned BANK_IDX_W = $clog2(BANK_W);
  localparam int unsigned SIG_SLOT   = 16;

  typedef enum logic [1:0] {
    SRC_PCM  = 2'd0,
    SRC_SIG  = 2'd1,
    SRC_BANK = 2'd2
  } src_e;

  // Mask bit that governs nibble half 'lower' of time slot 16 in frame 'frm'.
  // Upper half maps to slot frm, lower half to slot frm + NSLOT/2.
  function automatic logic [SLOT_W-1:0] mask_index(input logic [FRM_W-1:0] frm,
                                                   input logic lower);
    logic [SLOT_W-1:0] base;
    base = lower ? SLOT_W'(NSLOT / 2) : '0;
    return base + SLOT_W'(frm);
  endfunction

  // Bank bit sent at position bitn of frame frm: frm*SLOT_BITS + (SLOT_BITS-1-bitn).
  // The complement of bitn equals SLOT_BITS-1-bitn for a power-of-two slot width.
  function automatic logic [BANK_IDX_W-1:0] bank_index(input logic [FRM_W-1:0] frm,
                                                       input logic [BIT_W-1:0] bitn);
    return {frm, ~bitn};
  endfunction

  // Second half of a slot: bit positions SLOT_BITS/2 and above.
  function automatic logic is_lower_half(input logic [BIT_W-1:0] bitn);
    return bitn[BIT_W-1];
  endfunction

endpackage

// File: rtl/e1cas_pos_decode.sv
module e1cas_pos_decode
  import e1cas_pkg::*;
(
  input  logic [FRM_W-1:0]      frame_num,
  input  logic [SLOT_W-1:0]     slot_num,
  input  logic [BIT_W-1:0]      bit_num,
  output logic                  sig_slot,
  output logic                  lower_half,
  output logic [SLOT_W-1:0]     mask_idx,
  output logic [BANK_IDX_W-1:0] bank_idx
);

  always_comb begin
    sig_slot   = (slot_num == SLOT_W'(SIG_SLOT));
    lower_half = is_lower_half(bit_num);
    mask_idx   = mask_index(frame_num, lower_half);
    bank_idx   = bank_index(frame_num, bit_num);
  end

endmodule

// File: rtl/e1cas_src_sel.sv
module e1cas_src_sel
  import e1cas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sig_slot,
  input  logic mask_hit,
  input  logic mask_en,
  input  logic hw_sig_en,
  output src_e src
);

  always_comb begin
    src = SRC_PCM;
    if (sig_slot) begin
      if (mask_en && mask_hit) src = SRC_BANK;
      else if (hw_sig_en)      src = SRC_SIG;
    end
  end

  // Bank is never chosen while per-half selection is off
  p_maskoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |-> (src != SRC_BANK));

  // Outside time slot 16 the stream always wins
  p_ts_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_slot |-> (src == SRC_PCM));

endmodule

// File: rtl/e1cas_bit_mux.sv
module e1cas_bit_mux
  import e1cas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic pcm_bit,
  input  logic sig_bit,
  input  logic bank_bit,
  output logic out_bit
);

  localparam int unsigned NSRC = 3;

  logic [NSRC-1:0] cand;
  logic            nxt;

  assign cand = {bank_bit, sig_bit, pcm_bit};

  always_comb begin
    nxt = cand[0];
    if (int'(src) < NSRC) nxt = cand[src];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_bit <= 1'b0;
    else        out_bit <= nxt;
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (out_bit == 1'b0));

endmodule

// File: rtl/e1cas_ins_mux.sv
module e1cas_ins_mux
  import e1cas_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pcm_in,
  input  logic                  sig_in,
  input  logic [FRM_W-1:0]      frame_num,
  input  logic [SLOT_W-1:0]     slot_num,
  input  logic [BIT_W-1:0]      bit_num,
  input  logic                  hw_sig_en,
  input  logic                  mask_en,
  input  logic [NSLOT-1:0]      src_mask,
  input  logic [BANK_W-1:0]     sig_bank,
  output logic                  pcm_out
);

  logic                  sig_slot;
  logic                  lower_half;
  logic [SLOT_W-1:0]     mask_idx;
  logic [BANK_IDX_W-1:0] bank_idx;
  logic                  mask_hit;
  logic                  bank_bit;
  src_e                  src;
  logic                  src_bank;

  e1cas_pos_decode u_pos (
    .frame_num (frame_num),
    .slot_num  (slot_num),
    .bit_num   (bit_num),
    .sig_slot  (sig_slot),
    .lower_half(lower_half),
    .mask_idx  (mask_idx),
    .bank_idx  (bank_idx)
  );

  assign mask_hit = src_mask[mask_idx];
  assign bank_bit = sig_bank[bank_idx];

  e1cas_src_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_slot (sig_slot),
    .mask_hit (mask_hit),
    .mask_en  (mask_en),
    .hw_sig_en(hw_sig_en),
    .src      (src)
  );

  assign src_bank = (src == SRC_BANK);

  e1cas_bit_mux u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (src),
    .pcm_bit (pcm_in),
    .sig_bit (sig_in),
    .bank_bit(bank_bit),
    .out_bit (pcm_out)
  );

  // Non-signaling slots pass through one clock later
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_slot |=> (pcm_out == $past(pcm_in)));

  // Both features off: transparent
  p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_sig_en && !mask_en) |=> (pcm_out == $past(pcm_in)));

  // Stream signaling taken from the serial signaling input
  p_sig_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_slot && hw_sig_en && !src_bank) |=> (pcm_out == $past(sig_in)));

  // Bank-sourced bit appears on the line
  p_bank_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_bank |=> (pcm_out == $past(bank_bit)));

  // Half-select only when the governing mask bit is set
  p_half_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_bank |-> (mask_en && src_mask[mask_idx] && sig_slot));

endmodule

// File: tb/tb_e1cas_ins_mux.sv
module tb_e1cas_ins_mux;
  import e1cas_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  pcm_in, sig_in;
  logic [FRM_W-1:0]      frame_num;
  logic [SLOT_W-1:0]     slot_num;
  logic [BIT_W-1:0]      bit_num;
  logic                  hw_sig_en, mask_en;
  logic [NSLOT-1:0]      src_mask;
  logic [BANK_W-1:0]     sig_bank;
  logic                  pcm_out;
  logic [7:0]            bank_b [NFRM];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit pend = 0;
  bit pend_exp;
  string pend_tag;

  always #10 clk = ~clk;

  always_comb
    for (int k = 0; k < NFRM; k++) sig_bank[8*k +: 8] = bank_b[k];

  e1cas_ins_mux dut (
    .clk(clk), .rst_n(rst_n), .pcm_in(pcm_in), .sig_in(sig_in),
    .frame_num(frame_num), .slot_num(slot_num), .bit_num(bit_num),
    .hw_sig_en(hw_sig_en), .mask_en(mask_en), .src_mask(src_mask),
    .sig_bank(sig_bank), .pcm_out(pcm_out)
  );

  // Slot number of the mask bit governing a bit of time slot 16
  function automatic int gov_slot(int f, int b);
    int ch;
    bit lower;
    lower = (b >= 4);
    if (f == 0) return lower ? 16 : 0;
    ch = lower ? f + 15 : f;
    return (ch <= 15) ? ch : ch + 1;
  endfunction

  function automatic bit model(int f, int s, int b, bit p, bit g);
    if (s != 16) return p;
    if (mask_en && src_mask[gov_slot(f, b)]) return bank_b[f][7 - b];
    return hw_sig_en ? g : p;
  endfunction

  function automatic string tag_of(int f, int s, int b);
    int other;
    if (s != 16) return (!hw_sig_en && !mask_en) ? "R3" : "R2";
    if (mask_en && src_mask[gov_slot(f, b)]) begin
      if (f == 0)  return "R7";
      if (f == 10) return "R9";
      return "R5";
    end
    if (!mask_en && src_mask[gov_slot(f, b)]) return "R6";
    other = gov_slot(f, (b >= 4) ? 0 : 4);
    if (mask_en && src_mask[other]) return "R8";
    return (!hw_sig_en && !mask_en) ? "R3" : "R4";
  endfunction

  task automatic compare(bit exp, string tag);
    checks++;
    if (pcm_out !== exp) begin
      errors++;
      $display("FAIL %s: pcm_out=%b expected=%b (f=%0d s=%0d b=%0d prev)",
               tag, pcm_out, exp, frame_num, slot_num, bit_num);
    end
  endtask

  task automatic run_mf();
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 32; s++)
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          if (pend) compare(pend_exp, pend_tag);
          frame_num = FRM_W'(f);
          slot_num  = SLOT_W'(s);
          bit_num   = BIT_W'(b);
          pcm_in    = 1'($urandom);
          sig_in    = 1'($urandom);
          pend_exp  = model(f, s, b, pcm_in, sig_in);
          pend_tag  = tag_of(f, s, b);
          pend      = 1;
        end
  endtask

  task automatic rand_bank();
    for (int k = 0; k < NFRM; k++) bank_b[k] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; pcm_in = 1; sig_in = 1;
    frame_num = '0; slot_num = '0; bit_num = '0;
    hw_sig_en = 1; mask_en = 1; src_mask = '1;
    rand_bank();
    // R1: output held low in reset even with all sources high
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare(1'b0, "R1");
    end
    rst_n = 1;

    // R3/R6: both features off, random mask must do nothing
    hw_sig_en = 0; mask_en = 0; src_mask = 32'($urandom);
    run_mf();
    // R4/R6: stream signaling from sig_in, mask ignored
    hw_sig_en = 1; mask_en = 0; src_mask = '1;
    run_mf();
    // R5/R7/R8/R9: directed mix (frame-0 byte, channels 5 and 10)
    rand_bank();
    bank_b[0] = 8'h0B; bank_b[10] = 8'hA1;
    hw_sig_en = 1; mask_en = 1; src_mask = 32'h0001_0421;
    run_mf();
    // R5/R4: bank vs PCM with insertion off, random mask
    rand_bank();
    hw_sig_en = 0; mask_en = 1; src_mask = 32'($urandom);
    run_mf();
    // Random settings
    for (int r = 0; r < 2; r++) begin
      rand_bank();
      hw_sig_en = 1'($urandom); mask_en = 1; src_mask = 32'($urandom);
      run_mf();
    end
    // R3: all-zero mask with selection on but insertion off
    hw_sig_en = 0; mask_en = 1; src_mask = '0;
    run_mf();
    @(negedge clk);
    if (pend) compare(pend_exp, pend_tag);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule